// File: doc/BRIEF.md
# Double-Rate Character Fetch Serializer

This block sits between a character-cell timing generator and the video shift path and doubles the number of columns on screen while the timing generator keeps its programmed character count. For every character slot the generator announces, the block reads two consecutive bytes from screen memory. It tells them apart with a low-order address bit that it drives itself. Each byte is then used, together with the current scan line, to address a character generator ROM. The two resulting glyph rows leave on one serial pixel line, the first byte's row followed directly by the second.

All logic runs on the pixel clock. The timing generator marks the first pixel clock of each slot with a one-cycle `char_tick`. In that cycle the block samples the character address, the scan line and display enable. A slot is `2*PIX_W` pixel clocks long. Both memories are synchronous with one cycle of read latency and are modelled only in the testbench.

Top module: `dual_char_serializer`

## Requirements
- R1: In the first cycle after a `char_tick` cycle, `mem_addr` equals {address sampled at the tick, 0}. Bit 0 of `mem_addr` is 0 in every cycle of the slot except the one named in R2.
- R2: In the second cycle after the tick, `mem_addr` equals {sampled address, 1}. Bit 0 is 1 in exactly one cycle of each 16-cycle slot.
- R3: In the third cycle after the tick, `rom_addr` equals {byte read at half 0, scan_line}. In the fourth cycle, `rom_addr` equals {byte read at half 1, scan_line}.
- R4: In cycles 7 to 14 after the tick, `pix` carries the first glyph row, most significant bit first. In cycles 15 to 22, `pix` carries the second glyph row in the same order. With ticks 16 cycles apart, the pixel stream has no gap or repeat across slots.
- R5: If `disp_en` is 0 when the tick is sampled, all 16 pixels of that slot are 0.
- R6: During reset and in the first cycle after it, `pix`, `mem_addr` and `rom_addr` are all 0.
- R7: A `char_tick` restarts the slot sequence at any phase. An early tick makes the new slot follow the R1 to R4 timing counted from that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_tick | input | 1 | Marks the first pixel clock of a character slot |
| char_addr | input | ADDR_W | Character address from the timing generator |
| scan_line | input | LINE_W | Scan line within the character row |
| disp_en | input | 1 | Display enable from the timing generator |
| mem_addr | output | ADDR_W+1 | Screen memory address; bit 0 selects the half |
| mem_rdata | input | CODE_W | Screen memory data, one cycle after the address |
| rom_addr | output | CODE_W+LINE_W | Character ROM address {code, scan line} |
| rom_rdata | input | PIX_W | Glyph row, one cycle after the address |
| pix | output | 1 | Serial pixel output |

## Verification
Counting from the cycle in which `char_tick` is high, the memory address is due one and two cycles later. The ROM address is due three and four cycles later. The two memory latencies and the holding registers put the first pixel seven cycles after the tick, and the last pixel of the second glyph twenty-two cycles after it. The bench changes inputs and reads outputs on the falling clock edge. It counts falling edges from the tick, and each value is compared only at the exact offset given above. In the back-to-back and early-tick scenarios, the expected offsets are counted from the most recent tick.

// File: rtl/dual_char_serializer.sv
module dual_char_serializer #(
  parameter int ADDR_W = 11,
  parameter int LINE_W = 3,
  parameter int CODE_W = 8,
  parameter int PIX_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     char_tick,
  input  logic [ADDR_W-1:0]        char_addr,
  input  logic [LINE_W-1:0]        scan_line,
  input  logic                     disp_en,
  output logic [ADDR_W:0]          mem_addr,
  input  logic [CODE_W-1:0]        mem_rdata,
  output logic [CODE_W+LINE_W-1:0] rom_addr,
  input  logic [PIX_W-1:0]         rom_rdata,
  output logic                     pix
);
  localparam int SLOT   = 2 * PIX_W;
  localparam int PHW    = $clog2(SLOT);
  localparam int LOAD_A = 6;
  localparam int LOAD_B = LOAD_A + PIX_W;

  logic [PHW-1:0]    ph;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  logic              de_q, de_sh;
  logic [CODE_W-1:0] code;
  logic [PIX_W-1:0]  row_a, row_b, sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= '0;
      addr_q <= '0;
      line_q <= '0;
      de_q   <= 1'b0;
    end else begin
      if (char_tick) begin
        ph     <= PHW'(1);
        addr_q <= char_addr;
        line_q <= scan_line;
        de_q   <= disp_en;
      end else begin
        ph <= (ph == PHW'(SLOT - 1)) ? '0 : ph + PHW'(1);
      end
    end
  end

  assign mem_addr = {addr_q, ph == PHW'(2)};
  assign rom_addr = {code, line_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= '0;
      row_a <= '0;
      row_b <= '0;
    end else begin
      if (ph == PHW'(2) || ph == PHW'(3)) code <= mem_rdata;
      if (ph == PHW'(4)) row_a <= rom_rdata;
      if (ph == PHW'(5)) row_b <= rom_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      de_sh <= 1'b0;
    end else if (ph == PHW'(LOAD_A)) begin
      sh    <= row_a;
      de_sh <= de_q;
    end else if (ph == PHW'(LOAD_B)) begin
      sh    <= row_b;
      de_sh <= de_q;
    end else begin
      sh <= sh << 1;
    end
  end

  assign pix = sh[PIX_W-1] & de_sh;

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(char_tick) && $past(rst_n)) |-> (mem_addr[ADDR_W:1] == $past(char_addr) && !mem_addr[0]))
    else $error("addr_hold_chk");

  // R2
  half_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[0] |=> !mem_addr[0])
    else $error("half_once_chk");

  // R3
  rom_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PHW'(3)) |-> (rom_addr[CODE_W+LINE_W-1:LINE_W] == $past(mem_rdata)))
    else $error("rom_code_chk");

  // R4
  seam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PHW'(LOAD_B)) |=> (sh == $past(row_b)))
    else $error("seam_chk");

  // R6
  reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!pix && mem_addr == '0 && rom_addr == '0))
    else $error("reset_out_chk");

  // R7
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_tick |=> (ph == PHW'(1)))
    else $error("realign_chk");
endmodule

// File: tb/sim_dual_char_serializer.sv
module sim_dual_char_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_tick = 1'b0;
  logic [10:0] char_addr = '0;
  logic [2:0]  scan_line = '0;
  logic        disp_en = 1'b0;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [10:0] rom_addr;
  logic [7:0]  rom_rdata = '0;
  logic        pix;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_char_serializer u0 (
    .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .char_addr(char_addr),
    .scan_line(scan_line), .disp_en(disp_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata), .pix(pix)
  );

  function automatic logic [7:0] memf(input logic [11:0] a);
    return 8'((a * 37) + 11);
  endfunction

  function automatic logic [7:0] romf(input logic [7:0] c, input logic [2:0] l);
    return 8'((c * 13) + (l * 29) + 90);
  endfunction

  always_ff @(posedge clk) begin
    mem_rdata <= memf(mem_addr);
    rom_rdata <= romf(rom_addr[10:3], rom_addr[2:0]);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_pix(input logic [7:0] g0, input logic [7:0] g1, input int i);
    return (i < 8) ? g0[7 - i] : g1[15 - i];
  endfunction

  task automatic tick(input logic [10:0] a, input logic [2:0] l, input logic de);
    char_addr = a; scan_line = l; disp_en = de; char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; char_tick = 1'b1; char_addr = 11'h7FF; disp_en = 1'b1; scan_line = 3'h7;
    repeat (3) @(negedge clk);
    check(pix == 1'b0 && mem_addr == '0 && rom_addr == '0, "R6", "outputs in reset",
          {pix, mem_addr, rom_addr}, 0);
    rst_n = 1'b1; char_tick = 1'b0;
    @(negedge clk);
    check(pix == 1'b0 && mem_addr == '0 && rom_addr == '0, "R6", "outputs after reset",
          {pix, mem_addr, rom_addr}, 0);
  endtask

  task automatic t_single(input logic [10:0] a, input logic [2:0] l);
    logic [7:0] b0, b1, g0, g1;
    int ones = 0;
    b0 = memf({a, 1'b0}); b1 = memf({a, 1'b1});
    g0 = romf(b0, l); g1 = romf(b1, l);
    tick(a, l, 1'b1);
    for (int k = 1; k <= 22; k++) begin
      if (k <= 15) ones += int'(mem_addr[0]);
      if (k == 1) check(mem_addr == {a, 1'b0}, "R1", "first read address", mem_addr, {a, 1'b0});
      if (k == 2) check(mem_addr == {a, 1'b1}, "R2", "second read address", mem_addr, {a, 1'b1});
      if (k == 3) check(rom_addr == {b0, l}, "R3", "first rom address", rom_addr, {b0, l});
      if (k == 4) check(rom_addr == {b1, l}, "R3", "second rom address", rom_addr, {b1, l});
      if (k >= 7) check(pix == exp_pix(g0, g1, k - 7), "R4", "pixel", pix, exp_pix(g0, g1, k - 7));
      @(negedge clk);
    end
    check(ones == 1, "R2", "half-select cycles per slot", ones, 1);
  endtask

  task automatic t_blank(input logic [10:0] a, input logic [2:0] l);
    int lit = 0;
    tick(a, l, 1'b0);
    for (int k = 1; k <= 22; k++) begin
      if (k >= 7) lit += int'(pix);
      @(negedge clk);
    end
    check(lit == 0, "R5", "lit pixels with display disabled", lit, 0);
  endtask

  task automatic t_back2back(input logic [10:0] a, input logic [10:0] b, input logic [2:0] l);
    logic [7:0] ga0, ga1, gb0, gb1;
    ga0 = romf(memf({a, 1'b0}), l); ga1 = romf(memf({a, 1'b1}), l);
    gb0 = romf(memf({b, 1'b0}), l); gb1 = romf(memf({b, 1'b1}), l);
    tick(a, l, 1'b1);
    for (int k = 1; k <= 38; k++) begin
      if (k >= 7 && k <= 22)
        check(pix == exp_pix(ga0, ga1, k - 7), "R4", "seam pixel slot A", pix, exp_pix(ga0, ga1, k - 7));
      if (k >= 23)
        check(pix == exp_pix(gb0, gb1, k - 23), "R4", "seam pixel slot B", pix, exp_pix(gb0, gb1, k - 23));
      if (k == 16) begin
        char_addr = b; disp_en = 1'b1; char_tick = 1'b1;
      end
      if (k == 17) char_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_realign(input logic [10:0] a, input logic [10:0] b, input logic [2:0] l);
    logic [7:0] b0, b1, g0, g1;
    b0 = memf({b, 1'b0}); b1 = memf({b, 1'b1});
    g0 = romf(b0, l); g1 = romf(b1, l);
    tick(a, l, 1'b1);
    for (int k = 1; k <= 27; k++) begin
      if (k == 6) check(mem_addr == {b, 1'b0}, "R7", "early tick first read", mem_addr, {b, 1'b0});
      if (k == 7) check(mem_addr == {b, 1'b1}, "R7", "early tick second read", mem_addr, {b, 1'b1});
      if (k == 8) check(rom_addr == {b0, l}, "R7", "early tick rom address", rom_addr, {b0, l});
      if (k >= 12) check(pix == exp_pix(g0, g1, k - 12), "R7", "early tick pixel", pix, exp_pix(g0, g1, k - 12));
      if (k == 5) begin
        char_addr = b; char_tick = 1'b1;
      end
      if (k == 6) char_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single(11'h123, 3'd3);
    t_single(11'h7FE, 3'd7);
    t_single(11'h000, 3'd0);
    t_blank(11'h123, 3'd3);
    t_back2back(11'h045, 11'h3A9, 3'd5);
    t_realign(11'h111, 11'h5C2, 3'd2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule